// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block turns a processor core's request for an external access into the control waveform that an asynchronous memory or peripheral bus expects. It drives one active-low select line for each address space (program, data, I/O), a read/write level, and two active-low strobes, one for memory spaces and one for I/O. The selected lines stay asserted for the whole bus cycle. The address, and for writes the data, are held stable for the same span.

The length of each bus cycle comes from a packed wait-state configuration vector. The vector holds five 3-bit fields, one per address region. Program and data space are each split into a lower and an upper 32K-word half. I/O space forms a single region. A slow device can stretch a cycle beyond the programmed count by holding a READY input low. READY passes through a synchroniser, and the controller looks at it only in the final programmed wait cycle. At the end of every access the core receives a one-cycle completion pulse. For a read, the captured data word is presented at the same moment.

Top module: `xbus_wait_ctrl`

## Requirements
- R1: The outputs `prog_sel_n_o`, `data_sel_n_o` and `io_sel_n_o` are active low. During a bus cycle, exactly the one matching the requested space (code 0 program, 1 data, 2 I/O) is low, for every cycle of the access. All three are high when idle and after reset.
- R2: `rnw_o` is high throughout a read cycle, low throughout a write cycle, and high when idle.
- R3: Program and data accesses drive `mem_strb_n_o` low. I/O accesses drive `io_strb_n_o` low. A strobe is low in exactly the cycles in which a select is low, and the two strobes are never low together.
- R4: A request is accepted on the rising edge where `req_i` is high while idle. The strobe is low from the next cycle on. With a wait count of zero, the strobe stays low for exactly two cycles.
- R5: `wait_cfg_i` holds five 3-bit counts. Bits [2:0] serve program addresses below 8000h, [5:3] program at or above 8000h, [8:6] data below 8000h, [11:9] data at or above 8000h, and [14:12] all of I/O space. A count N gives a strobe low time of 2+N cycles, with N from 0 to 7.
- R6: Within program and data space, address bit 15 picks the region. In I/O space, bit 15 has no effect on the cycle length.
- R7: READY passes through two flip-flops and is looked at only in the last programmed wait cycle. While it is seen low there, the cycle is extended one cycle at a time. When `ready_i` rises, the strobe stays low for exactly three more sampled cycles. With a count of zero, READY has no effect.
- R8: `xdata_oe_o` is high only during a write bus cycle, with `xdata_o` equal to the write data. It is low during reads and when idle.
- R9: `done_o` is high for exactly one cycle: the first cycle in which the strobe is high again after an access. On a read, `rdata_o` then holds the value of `xdata_i` from the last strobe-low cycle.
- R10: A request raised while a bus cycle is in progress is ignored. It neither alters the running cycle nor starts another one. A request with space code 3 is also ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Access request from the core |
| req_space_i | input | 2 | Address space of the request: 0 program, 1 data, 2 I/O |
| req_write_i | input | 1 | 1 for a write, 0 for a read |
| req_addr_i | input | AW (16) | Word address within the space |
| req_wdata_i | input | DW (16) | Write data |
| wait_cfg_i | input | 15 | Five packed 3-bit wait counts |
| ready_i | input | 1 | Asynchronous device-ready input |
| xaddr_o | output | AW (16) | External address |
| xdata_o | output | DW (16) | External data out |
| xdata_oe_o | output | 1 | Output enable for the data pad |
| xdata_i | input | DW (16) | External data in |
| prog_sel_n_o | output | 1 | Program space select, active low |
| data_sel_n_o | output | 1 | Data space select, active low |
| io_sel_n_o | output | 1 | I/O space select, active low |
| rnw_o | output | 1 | Read (high) or write (low) |
| mem_strb_n_o | output | 1 | Memory strobe, active low |
| io_strb_n_o | output | 1 | I/O strobe, active low |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW (16) | Captured read data |

## Verification
The in-line assertions check the relationships that must hold on every clock:
- at most one select is low;
- strobes track selects, and the I/O strobe only appears with the I/O select;
- the data driver is enabled only inside a write;
- the completion pulse follows a strobe;
- address and select stay stable inside a cycle.

Cycle lengths can only be shown by the directed scenarios, which count strobe-low cycles against the expected value. Those scenarios cover the per-region wait counts (including the maximum of seven), the address-bit region choice, the exact stretch after READY rises, and the rejection of requests that are mid-cycle or carry an invalid space code.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [1:0] {
      SP_PROG = 2'd0,
      SP_DATA = 2'd1,
      SP_IO   = 2'd2,
      SP_NONE = 2'd3
   } space_e;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_T1   = 2'd1,
      PH_WAIT = 2'd2,
      PH_T2   = 2'd3
   } phase_e;

   localparam int unsigned NUM_REGIONS = 5;
endpackage

// File: rtl/xbus_ready_sync.sv
module xbus_ready_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic sync_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xbus_ready_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b1;
            else        chain_q[s] <= raw_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= 1'b1;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/xbus_ws_select.sv
module xbus_ws_select
   import xbus_pkg::*;
#(
   parameter int unsigned WS_W = 3
) (
   input  space_e                        space_i,
   input  logic                          upper_i,
   input  logic [NUM_REGIONS*WS_W-1:0]   cfg_i,
   output logic [WS_W-1:0]               ws_o
);
   localparam int unsigned IDX_W = $clog2(NUM_REGIONS);

   if (WS_W < 1) begin : g_bad_ws
      $error("xbus_ws_select: WS_W must be positive");
   end

   logic [WS_W-1:0]  field_a [NUM_REGIONS];
   logic [IDX_W-1:0] idx;

   for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_field
      assign field_a[g] = cfg_i[g*WS_W +: WS_W];
   end

   always_comb begin
      case (space_i)
         SP_PROG: idx = upper_i ? IDX_W'(1) : IDX_W'(0);
         SP_DATA: idx = upper_i ? IDX_W'(3) : IDX_W'(2);
         SP_IO:   idx = IDX_W'(4);
         default: idx = IDX_W'(0);
      endcase
   end

   assign ws_o = field_a[idx];
endmodule

// File: rtl/xbus_cycle_fsm.sv
module xbus_cycle_fsm
   import xbus_pkg::*;
#(
   parameter int unsigned AW   = 16,
   parameter int unsigned DW   = 16,
   parameter int unsigned WS_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_i,
   input  space_e          space_i,
   input  logic            write_i,
   input  logic [AW-1:0]   addr_i,
   input  logic [DW-1:0]   wdata_i,
   input  logic [WS_W-1:0] ws_i,
   input  logic            ready_s_i,
   input  logic [DW-1:0]   xdata_i,
   output logic [AW-1:0]   xaddr_o,
   output logic [DW-1:0]   xdata_o,
   output logic            xdata_oe_o,
   output logic [2:0]      sel_n_o,
   output logic            rnw_o,
   output logic            mem_strb_n_o,
   output logic            io_strb_n_o,
   output logic            done_o,
   output logic [DW-1:0]   rdata_o
);
   localparam logic [WS_W-1:0] CNT_ONE = WS_W'(1);

   phase_e          phase_q;
   logic [WS_W-1:0] cnt_q;
   logic [AW-1:0]   addr_q;
   logic [DW-1:0]   wdata_q, rdata_q;
   logic [2:0]      sel_n_q;
   logic            rnw_q, oe_q, mstrb_n_q, iostrb_n_q, done_q;
   logic            accept;

   assign accept = (phase_q == PH_IDLE) && req_i && (space_i != SP_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q    <= PH_IDLE;
         cnt_q      <= '0;
         addr_q     <= '0;
         wdata_q    <= '0;
         rdata_q    <= '0;
         sel_n_q    <= 3'b111;
         rnw_q      <= 1'b1;
         oe_q       <= 1'b0;
         mstrb_n_q  <= 1'b1;
         iostrb_n_q <= 1'b1;
         done_q     <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: begin
               if (accept) begin
                  phase_q    <= PH_T1;
                  cnt_q      <= ws_i;
                  addr_q     <= addr_i;
                  wdata_q    <= wdata_i;
                  rnw_q      <= ~write_i;
                  oe_q       <= write_i;
                  sel_n_q[0] <= (space_i != SP_PROG);
                  sel_n_q[1] <= (space_i != SP_DATA);
                  sel_n_q[2] <= (space_i != SP_IO);
                  mstrb_n_q  <= (space_i == SP_IO);
                  iostrb_n_q <= (space_i != SP_IO);
               end
            end
            PH_T1: begin
               phase_q <= (cnt_q == '0) ? PH_T2 : PH_WAIT;
            end
            PH_WAIT: begin
               if (cnt_q > CNT_ONE) cnt_q <= cnt_q - CNT_ONE;
               else if (ready_s_i)  phase_q <= PH_T2;
            end
            PH_T2: begin
               phase_q    <= PH_IDLE;
               done_q     <= 1'b1;
               if (rnw_q) rdata_q <= xdata_i;
               sel_n_q    <= 3'b111;
               rnw_q      <= 1'b1;
               oe_q       <= 1'b0;
               mstrb_n_q  <= 1'b1;
               iostrb_n_q <= 1'b1;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign xaddr_o      = addr_q;
   assign xdata_o      = wdata_q;
   assign xdata_oe_o   = oe_q;
   assign sel_n_o      = sel_n_q;
   assign rnw_o        = rnw_q;
   assign mem_strb_n_o = mstrb_n_q;
   assign io_strb_n_o  = iostrb_n_q;
   assign done_o       = done_q;
   assign rdata_o      = rdata_q;

   // R1
   sel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~sel_n_q) <= 1);

   // R3
   strobe_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(mstrb_n_q && iostrb_n_q)) == (sel_n_q != 3'b111));

   // R3
   io_strobe_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !iostrb_n_q |-> (!sel_n_q[2] && mstrb_n_q));

   // R8
   oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_q |-> (!rnw_q && !(mstrb_n_q && iostrb_n_q)));

   // R9
   done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> (mstrb_n_q && iostrb_n_q && !($past(mstrb_n_q) && $past(iostrb_n_q))));

   // R10
   cycle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q != PH_IDLE && $past(phase_q) != PH_IDLE) |->
         ($stable(addr_q) && $stable(sel_n_q) && $stable(rnw_q)));
endmodule

// File: rtl/xbus_wait_ctrl.sv
module xbus_wait_ctrl
   import xbus_pkg::*;
#(
   parameter int unsigned AW          = 16,
   parameter int unsigned DW          = 16,
   parameter int unsigned WS_W        = 3,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned CFG_W      = NUM_REGIONS * WS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_i,
   input  logic [1:0]       req_space_i,
   input  logic             req_write_i,
   input  logic [AW-1:0]    req_addr_i,
   input  logic [DW-1:0]    req_wdata_i,
   input  logic [CFG_W-1:0] wait_cfg_i,
   input  logic             ready_i,
   output logic [AW-1:0]    xaddr_o,
   output logic [DW-1:0]    xdata_o,
   output logic             xdata_oe_o,
   input  logic [DW-1:0]    xdata_i,
   output logic             prog_sel_n_o,
   output logic             data_sel_n_o,
   output logic             io_sel_n_o,
   output logic             rnw_o,
   output logic             mem_strb_n_o,
   output logic             io_strb_n_o,
   output logic             done_o,
   output logic [DW-1:0]    rdata_o
);
   if (AW < 2) begin : g_bad_aw
      $error("xbus_wait_ctrl: AW must be at least 2");
   end
   if (DW < 1) begin : g_bad_dw
      $error("xbus_wait_ctrl: DW must be positive");
   end

   space_e          space;
   logic [WS_W-1:0] ws;
   logic            ready_s;
   logic [2:0]      sel_n;

   assign space = space_e'(req_space_i);

   xbus_ready_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (ready_i),
      .sync_o (ready_s)
   );

   xbus_ws_select #(.WS_W(WS_W)) u_ws (
      .space_i (space),
      .upper_i (req_addr_i[AW-1]),
      .cfg_i   (wait_cfg_i),
      .ws_o    (ws)
   );

   xbus_cycle_fsm #(.AW(AW), .DW(DW), .WS_W(WS_W)) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_i        (req_i),
      .space_i      (space),
      .write_i      (req_write_i),
      .addr_i       (req_addr_i),
      .wdata_i      (req_wdata_i),
      .ws_i         (ws),
      .ready_s_i    (ready_s),
      .xdata_i      (xdata_i),
      .xaddr_o      (xaddr_o),
      .xdata_o      (xdata_o),
      .xdata_oe_o   (xdata_oe_o),
      .sel_n_o      (sel_n),
      .rnw_o        (rnw_o),
      .mem_strb_n_o (mem_strb_n_o),
      .io_strb_n_o  (io_strb_n_o),
      .done_o       (done_o),
      .rdata_o      (rdata_o)
   );

   assign prog_sel_n_o = sel_n[0];
   assign data_sel_n_o = sel_n[1];
   assign io_sel_n_o   = sel_n[2];
endmodule

// File: tb/xbus_wait_ctrl_tb.sv
module xbus_wait_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_i = 1'b0;
   logic [1:0]  req_space_i = 2'd0;
   logic        req_write_i = 1'b0;
   logic [15:0] req_addr_i = '0;
   logic [15:0] req_wdata_i = '0;
   logic [14:0] wait_cfg_i;
   logic        ready_i = 1'b1;
   logic [15:0] xaddr_o, xdata_o, xdata_i = '0, rdata_o;
   logic        xdata_oe_o, prog_sel_n_o, data_sel_n_o, io_sel_n_o;
   logic        rnw_o, mem_strb_n_o, io_strb_n_o, done_o;

   int checks = 0;
   int errors = 0;

   // R5 field map: {io=4, data upper=7, data lower=1, prog upper=2, prog lower=0}
   assign wait_cfg_i = {3'd4, 3'd7, 3'd1, 3'd2, 3'd0};

   always #5 clk = ~clk;

   xbus_wait_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_space_i(req_space_i),
      .req_write_i(req_write_i), .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
      .wait_cfg_i(wait_cfg_i), .ready_i(ready_i), .xaddr_o(xaddr_o),
      .xdata_o(xdata_o), .xdata_oe_o(xdata_oe_o), .xdata_i(xdata_i),
      .prog_sel_n_o(prog_sel_n_o), .data_sel_n_o(data_sel_n_o),
      .io_sel_n_o(io_sel_n_o), .rnw_o(rnw_o), .mem_strb_n_o(mem_strb_n_o),
      .io_strb_n_o(io_strb_n_o), .done_o(done_o), .rdata_o(rdata_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] sels();
      return {io_sel_n_o, data_sel_n_o, prog_sel_n_o};
   endfunction

   // One access; rel_at raises READY at that low sample, inj_at injects a busy request
   task automatic run_access(input logic [1:0] sp, input logic wr, input logic [15:0] ad,
                             input logic [15:0] wd, input logic [15:0] rd, input int exp_len,
                             input int rel_at, input int inj_at, input string tag);
      int len = 0;
      bit bad = 0;
      logic [2:0] exp_sel;
      exp_sel = ~(3'b001 << sp);
      @(negedge clk);
      req_i = 1'b1; req_space_i = sp; req_write_i = wr;
      req_addr_i = ad; req_wdata_i = wd; xdata_i = rd;
      @(negedge clk);
      req_i = 1'b0;
      while (!(mem_strb_n_o && io_strb_n_o) && len < 40) begin
         len++;
         if (sels() != exp_sel) bad = 1;
         if (rnw_o != !wr) bad = 1;
         if (mem_strb_n_o != (sp == 2'd2) || io_strb_n_o != (sp != 2'd2)) bad = 1;
         if (xdata_oe_o != wr || xaddr_o != ad) bad = 1;
         if (wr && xdata_o != wd) bad = 1;
         if (len == rel_at) ready_i = 1'b1;
         if (len == inj_at) begin
            req_i = 1'b1; req_space_i = 2'd2; req_write_i = ~wr; req_addr_i = ~ad;
         end else if (len == inj_at + 1) req_i = 1'b0;
         @(negedge clk);
      end
      check(!bad, "R1/R2/R3/R8", {tag, " signals during cycle"}, bad, 0);
      check(len == exp_len, "R4/R5", {tag, " strobe length"}, len, exp_len);
      check(done_o == 1'b1 && sels() == 3'b111 && rnw_o && !xdata_oe_o, "R9",
            {tag, " done at strobe end"}, {done_o, sels()}, 4'hF);
      if (!wr) check(rdata_o == rd, "R9", {tag, " read data"}, rdata_o, rd);
      @(negedge clk);
      check(!done_o && mem_strb_n_o && io_strb_n_o, "R9", {tag, " done one cycle"},
            {done_o, mem_strb_n_o, io_strb_n_o}, 3'b011);
   endtask

   task automatic t_reset();
      check(sels() == 3'b111, "R1", "reset selects", sels(), 3'b111);
      check(rnw_o && mem_strb_n_o && io_strb_n_o, "R2/R3", "reset rnw/strobes",
            {rnw_o, mem_strb_n_o, io_strb_n_o}, 3'b111);
      check(!xdata_oe_o && !done_o, "R8/R9", "reset oe/done", {xdata_oe_o, done_o}, 0);
   endtask

   task automatic t_program();
      run_access(2'd0, 1'b0, 16'h0123, 16'h0, 16'hA5A5, 2, 0, 0, "R4 prog lower");
      run_access(2'd0, 1'b0, 16'h8123, 16'h0, 16'h5A5A, 4, 0, 0, "R6 prog upper");
   endtask

   task automatic t_data();
      run_access(2'd1, 1'b1, 16'h0040, 16'hBEEF, 16'h0, 3, 0, 0, "R5 data lower write");
      run_access(2'd1, 1'b0, 16'hF000, 16'h0, 16'h1357, 9, 0, 0, "R5 data upper max");
   endtask

   task automatic t_io();
      run_access(2'd2, 1'b0, 16'h0010, 16'h0, 16'h2468, 6, 0, 0, "R3 io lower");
      run_access(2'd2, 1'b0, 16'h8010, 16'h0, 16'h1111, 6, 0, 0, "R6 io upper");
      run_access(2'd2, 1'b1, 16'h0007, 16'hC0DE, 16'h0, 6, 0, 0, "R8 io write");
   endtask

   task automatic t_ready();
      ready_i = 1'b0;
      repeat (3) @(negedge clk);
      // R7: count 1, held 6 samples, release adds 3
      run_access(2'd1, 1'b0, 16'h0001, 16'h0, 16'h7777, 9, 6, 0, "R7 stretch");
      ready_i = 1'b0;
      repeat (3) @(negedge clk);
      // R7: count 0 ignores READY
      run_access(2'd0, 1'b1, 16'h0002, 16'h4321, 16'h0, 2, 0, 0, "R7 zero wait");
      ready_i = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_ignore();
      bit seen = 0;
      // R10: request during active cycle
      run_access(2'd0, 1'b0, 16'h9000, 16'h0, 16'h0F0F, 4, 0, 1, "R10 busy request");
      repeat (3) begin
         @(negedge clk);
         if (!(mem_strb_n_o && io_strb_n_o) || done_o) seen = 1;
      end
      check(!seen, "R10", "no follow-on cycle", seen, 0);
      // R10: space code 3
      seen = 0;
      req_i = 1'b1; req_space_i = 2'd3; req_write_i = 1'b0;
      @(negedge clk);
      req_i = 1'b0;
      repeat (3) begin
         if (!(mem_strb_n_o && io_strb_n_o) || sels() != 3'b111 || done_o) seen = 1;
         @(negedge clk);
      end
      check(!seen, "R10", "space code 3 ignored", seen, 0);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_program();
      t_data();
      t_io();
      t_ready();
      t_ignore();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule